// File: doc/BRIEF.md
# LED Channel PWM With Fade Ramp

This block drives one LED channel in direct-brightness mode. An 8-bit target brightness sets the duty of a 256-step PWM waveform. Level 0 is dark and level 255 is the brightest setting. The block keeps its own current duty level. When the glide for a given direction is off, a new target is taken at once. When the glide is on, the level moves toward the target one step at a time.

Upward glides are paced by the rise code and downward glides by the fall code. Each code is 3 bits. A code c gives a full 0-to-255 ramp of about 0.13 s × 2^c with a 16 MHz clock. A prescaler, set by a parameter, makes the base step tick, and each level step waits 2^c of those ticks. The default prescaler suits a 16 MHz clock. A smaller value shortens all timing for simulation.

A mode input selects programmed mode, in which both glides are ignored. Channel and global enables gate the PWM output. A 2-bit drive-current code passes straight through to an external current driver.

Top module: `ledch_fade_pwm`

## Requirements
- R1: After reset, the internal level and its rate counter are 0, the PWM phase counter is 0, and pwm_o is 0.
- R2: The PWM phase counter runs over 0..255 and then repeats. The cycle after a clock edge at which the enables are set and the phase is below the level, pwm_o is 1. A steady level L therefore gives exactly L high cycles in every 256. Level 0 never drives the output high, and level 255 gives 255 high cycles in 256.
- R3: If the target is above the level and fade_in_en_i is 0, or below the level and fade_out_en_i is 0, the level takes the target value at the next clock edge.
- R4: If the target is above the level, fade_in_en_i is 1 and mode_i is 0, the level rises by exactly 1 once per 2^rise_code_i step ticks and never passes the target.
- R5: If the target is below the level, fade_out_en_i is 1 and mode_i is 0, the level falls by exactly 1 once per 2^fall_code_i step ticks and never passes the target.
- R6: With mode_i at 1, both fade enables are ignored, and every target change is taken at once as in R3.
- R7: A target change during a glide turns the glide toward the new target from the current level. The rate counter is not restarted.
- R8: pwm_o is 0 one cycle after any edge at which ch_en_i or glb_en_i is 0. The level keeps being tracked while the output is off.
- R9: imax_o always equals imax_i. The codes are 00 for 0 mA, 01 for 5 mA, 10 for 10 mA and 11 for 15 mA.
- R10: A step tick occurs on every PRESCALE-th clock, counted without stopping from reset. The rate counter is cleared whenever the level equals the target or jumps to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (16 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_i | input | 8 | Target brightness level |
| fade_in_en_i | input | 1 | Glide enable for upward changes |
| fade_out_en_i | input | 1 | Glide enable for downward changes |
| mode_i | input | 1 | 1 = programmed mode, glides ignored |
| rise_code_i | input | 3 | Rate code for upward glides |
| fall_code_i | input | 3 | Rate code for downward glides |
| ch_en_i | input | 1 | Channel enable |
| glb_en_i | input | 1 | Global enable |
| imax_i | input | 2 | Drive-current code |
| pwm_o | output | 1 | PWM output |
| imax_o | output | 2 | Drive-current code to the driver |

## Verification
The bench goes after the step pacing under different rise and fall codes. A design that restarts or misreads the rate counter would reach the target early or late, and its duty would drift from the model within a few cycles. Redirecting a glide mid-ramp is tested explicitly, because a design that finishes the old glide first or resets the counter would diverge there. The bench also covers fades requested while in programmed mode, glides enabled in one direction only, and the duty at the two extreme levels. A design that lets the phase reach the level inclusively would show 256 high cycles at level 255 and one at level 0.

// File: rtl/ledch_pkg.sv
package ledch_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/ledch_tick.sv
module ledch_tick #(
  parameter int unsigned PRESCALE = 8157
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             pre_q <= '0;
        else if (pre_q == LAST)  pre_q <= '0;
        else                     pre_q <= pre_q + PRE_W'(1);
      end
      assign tick_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ledch_ramp.sv
module ledch_ramp
  import ledch_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [LVL_W-1:0]  tgt_i,
  input  logic              glide_up_i,
  input  logic              glide_dn_i,
  input  logic [CODE_W-1:0] rise_code_i,
  input  logic [CODE_W-1:0] fall_code_i,
  output logic [LVL_W-1:0]  lvl_o
);
  localparam int unsigned RATE_W = (1 << CODE_W) - 1;

  ramp_dir_e         dir;
  logic [CODE_W-1:0] code;
  logic [RATE_W-1:0] limit;
  logic [RATE_W-1:0] cnt_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              glide;

  always_comb begin
    if (lvl_q < tgt_i)      dir = DIR_UP;
    else if (lvl_q > tgt_i) dir = DIR_DOWN;
    else                    dir = DIR_HOLD;
    code  = (dir == DIR_DOWN) ? fall_code_i : rise_code_i;
    limit = RATE_W'((1 << code) - 1);
    case (dir)
      DIR_UP:   glide = glide_up_i;
      DIR_DOWN: glide = glide_dn_i;
      default:  glide = 1'b0;
    endcase
  end

  // rate counter survives redirects; cleared only on hold or jump
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else if (dir == DIR_HOLD) begin
      cnt_q <= '0;
    end else if (!glide) begin
      lvl_q <= tgt_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit) begin
        cnt_q <= '0;
        lvl_q <= (dir == DIR_UP) ? lvl_q + LVL_W'(1) : lvl_q - LVL_W'(1);
      end else begin
        cnt_q <= cnt_q + RATE_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/ledch_pwm.sv
module ledch_pwm #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             pwm_o
);
  logic [LVL_W-1:0] phase_q;
  logic             pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      phase_q <= phase_q + LVL_W'(1);
      pwm_q   <= en_i && (phase_q < lvl_i);
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/ledch_fade_pwm.sv
module ledch_fade_pwm
  import ledch_pkg::*;
#(
  parameter int unsigned PRESCALE = 8157,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned CUR_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  tgt_i,
  input  logic              fade_in_en_i,
  input  logic              fade_out_en_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] rise_code_i,
  input  logic [CODE_W-1:0] fall_code_i,
  input  logic              ch_en_i,
  input  logic              glb_en_i,
  input  logic [CUR_W-1:0]  imax_i,
  output logic              pwm_o,
  output logic [CUR_W-1:0]  imax_o
);
  logic             tick;
  logic [LVL_W-1:0] lvl_q;
  logic             glide_up;
  logic             glide_dn;

  // glides only honoured in direct mode
  assign glide_up = fade_in_en_i  & ~mode_i;
  assign glide_dn = fade_out_en_i & ~mode_i;

  ledch_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ledch_ramp #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .tgt_i       (tgt_i),
    .glide_up_i  (glide_up),
    .glide_dn_i  (glide_dn),
    .rise_code_i (rise_code_i),
    .fall_code_i (fall_code_i),
    .lvl_o       (lvl_q)
  );

  ledch_pwm #(.LVL_W(LVL_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ch_en_i & glb_en_i),
    .lvl_i  (lvl_q),
    .pwm_o  (pwm_o)
  );

  assign imax_o = imax_i;
endmodule

// File: rtl/ledch_fade_pwm_chk.sv
module ledch_fade_pwm_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] tgt_i,
  input logic             fade_in_en_i,
  input logic             fade_out_en_i,
  input logic             mode_i,
  input logic             ch_en_i,
  input logic             glb_en_i,
  input logic             pwm_o,
  input logic [LVL_W-1:0] lvl_i
);
  a_r8_forced_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch_en_i && glb_en_i) |=> !pwm_o);

  a_r2_dark_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |=> !pwm_o);

  a_r3_jump_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i < tgt_i && (!fade_in_en_i || mode_i)) |=> (lvl_i == $past(tgt_i)));

  a_r3_jump_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i > tgt_i && (!fade_out_en_i || mode_i)) |=> (lvl_i == $past(tgt_i)));

  a_r4_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i < tgt_i && fade_in_en_i && !mode_i)
      |=> (lvl_i == $past(lvl_i) || lvl_i == $past(lvl_i) + LVL_W'(1)));

  a_r5_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i > tgt_i && fade_out_en_i && !mode_i)
      |=> (lvl_i == $past(lvl_i) || lvl_i == $past(lvl_i) - LVL_W'(1)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == tgt_i) |=> $stable(lvl_i));
endmodule

bind ledch_fade_pwm ledch_fade_pwm_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tgt_i         (tgt_i),
  .fade_in_en_i  (fade_in_en_i),
  .fade_out_en_i (fade_out_en_i),
  .mode_i        (mode_i),
  .ch_en_i       (ch_en_i),
  .glb_en_i      (glb_en_i),
  .pwm_o         (pwm_o),
  .lvl_i         (lvl_q)
);

// File: tb/ledch_fade_pwm_tb_top.sv
module ledch_fade_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tgt = '0;
  logic       fin = 1'b0, fout = 1'b0, mode = 1'b0;
  logic [2:0] rise = '0, fall = '0;
  logic       ch_en = 1'b0, glb_en = 1'b0;
  logic [1:0] imax = '0;
  logic       pwm;
  logic [1:0] imax_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ledch_fade_pwm #(.PRESCALE(PRESCALE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tgt_i(tgt),
    .fade_in_en_i(fin), .fade_out_en_i(fout), .mode_i(mode),
    .rise_code_i(rise), .fall_code_i(fall),
    .ch_en_i(ch_en), .glb_en_i(glb_en), .imax_i(imax),
    .pwm_o(pwm), .imax_o(imax_out)
  );

  // behavioural reference model
  int m_pre, m_lvl, m_cnt, m_phase;
  bit m_pwm;
  always @(posedge clk or negedge rst_n) begin
    bit tk, up, gl, nxt;
    int code;
    if (!rst_n) begin
      m_pre = 0; m_lvl = 0; m_cnt = 0; m_phase = 0; m_pwm = 0;
    end else begin
      tk = (m_pre == PRESCALE - 1);
      m_pre = tk ? 0 : m_pre + 1;
      nxt = ch_en && glb_en && (m_phase < m_lvl);
      m_phase = (m_phase + 1) % 256;
      if (m_lvl == int'(tgt)) m_cnt = 0;
      else begin
        up = m_lvl < int'(tgt);
        gl = up ? (fin && !mode) : (fout && !mode);
        code = up ? int'(rise) : int'(fall);
        if (!gl) begin m_lvl = int'(tgt); m_cnt = 0; end
        else if (tk) begin
          if (m_cnt >= (1 << code) - 1) begin m_cnt = 0; m_lvl += up ? 1 : -1; end
          else m_cnt++;
        end
      end
      m_pwm = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm !== m_pwm) begin
        errors++;
        $display("FAIL %s pwm cycle %0d actual %0b expected %0b", cur_req, cyc, pwm, m_pwm);
      end
      checks++;
      if (imax_out !== imax) begin
        errors++;
        $display("FAIL R9 imax actual %0b expected %0b", imax_out, imax);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic duty_check(input int exp, input string req);
    int hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    checks++;
    if (hi != exp) begin
      errors++;
      $display("FAIL %s duty actual %0d expected %0d", req, hi, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (pwm !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset pwm actual %0b expected 0", pwm);
    end
    cur_req = "R1";
    ch_en = 1; glb_en = 1;
    duty_check(0, "R1");

    // R3 jump, R2 extreme duties
    cur_req = "R3"; tgt = 8'd128; wait_cyc(4); duty_check(128, "R3");
    cur_req = "R2"; tgt = 8'd255; wait_cyc(4); duty_check(255, "R2");
    tgt = 8'd0; wait_cyc(4); duty_check(0, "R2");

    // R4 rise code 0, then code 3
    cur_req = "R4"; fin = 1; rise = 3'd0; tgt = 8'd200;
    wait_cyc(20);
    wait_cyc(400); duty_check(200, "R4");
    fin = 0; tgt = 8'd0; wait_cyc(4);
    cur_req = "R10"; fin = 1; rise = 3'd3; tgt = 8'd20;
    wait_cyc(340); duty_check(20, "R10");

    // R3: fade-out only, upward change jumps
    cur_req = "R3"; fin = 0; fout = 1; tgt = 8'd200; wait_cyc(4); duty_check(200, "R3");

    // R5 fall code 1
    cur_req = "R5"; fall = 3'd1; tgt = 8'd50;
    wait_cyc(620); duty_check(50, "R5");

    // R7 redirect
    cur_req = "R7"; fout = 0; tgt = 8'd0; wait_cyc(4);
    fin = 1; fout = 1; rise = 3'd0; fall = 3'd0; tgt = 8'd100;
    wait_cyc(61); tgt = 8'd10;
    wait_cyc(120); duty_check(10, "R7");

    // R6 programmed mode ignores fades
    cur_req = "R6"; mode = 1; tgt = 8'd180; wait_cyc(3); duty_check(180, "R6");
    tgt = 8'd30; wait_cyc(3); duty_check(30, "R6");
    mode = 0;

    // R8 enables gate output, level keeps tracking
    cur_req = "R8"; ch_en = 0; fin = 0; fout = 0; tgt = 8'd90; wait_cyc(3); duty_check(0, "R8");
    ch_en = 1; glb_en = 0; wait_cyc(3); duty_check(0, "R8");
    glb_en = 1; wait_cyc(3); duty_check(90, "R8");

    // R9 current code pass-through
    cur_req = "R9";
    for (int c = 0; c < 4; c++) begin
      imax = 2'(c);
      #1;
      checks++;
      if (imax_out !== 2'(c)) begin
        errors++;
        $display("FAIL R9 code actual %0b expected %0b", imax_out, 2'(c));
      end
      wait_cyc(2);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule